// File: doc/BRIEF.md
# EEPROM Page Programmer

This block is a host-side controller that writes a block of bytes into a parallel, byte-wide EEPROM. A start pulse carries a start address, a byte count and a choice of completion-polling method. The bytes then arrive on a valid/ready stream. The controller drives the chip-enable, output-enable and write-enable lines, the address and the write data. It groups consecutive bytes into load runs. Each run stays inside one 64-byte page, and each keeps the spacing between write strobes below the memory's byte-load window.

After every run the controller reads the memory back until the internal programming cycle has finished, and only then starts the next run. Two completion tests are offered. The first is a data-compare test: the controller re-reads the last byte written until it comes back with its true bit 7, which means the whole byte matches. The second is a toggle test: the controller reads until two reads in a row agree on bit 6.

If the input stream stalls for so long that the load window would lapse, the controller closes the run early and polls. When polling runs longer than a set limit, the operation stops with an error flag. A clean finish gives a one-cycle done pulse with every bus control back high.

Top module: `eeprom_page_prog`

## Requirements
- R1: After reset, and whenever busy_o is low, chip enable, output enable and write enable are high, mem_drive_o is low, in_ready_o, done_o and timeout_err_o are low.
- R2: Each write strobe holds mem_ce_n_o and mem_we_n_o low with mem_oe_n_o high and mem_drive_o high, for exactly STROBE_CYC cycles, with address and data set up SETUP_CYC cycles before the strobe.
- R3: Bytes accepted on in_valid_i and in_ready_o in the same cycle are written to consecutive addresses from start_addr_i, and each one holds its value in the memory once the operation ends.
- R4: Every write strobe between two poll phases uses the same address bits above the low PAGE_W bits. A run closes after the byte at a page's last address.
- R5: Within a run, the falling edges of two consecutive write strobes are at most WINDOW_CYC cycles apart. If no byte arrives in time, the run closes and is polled before the next byte is taken.
- R6: Poll reads hold mem_ce_n_o and mem_oe_n_o low with mem_we_n_o high and mem_drive_o low, at the address of the last byte written. With poll_mode_i = 0, polling ends on a read equal to that byte, which includes its true bit 7.
- R7: With poll_mode_i = 1 (latched at start), polling ends when two consecutive poll reads return the same bit 6.
- R8: No write strobe is issued while the memory is still programming a previous run.
- R9: After the last run completes its polling, done_o is high for exactly one cycle and busy_o then falls.
- R10: If a poll phase lasts POLL_TIMEOUT cycles without completing, the operation stops with busy_o low, timeout_err_o high and no done pulse. timeout_err_o stays high until the next start.
- R11: A start with byte_count_i = 0 gives a done pulse in the cycle after the start with no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when idle |
| start_addr_i | input | ADDR_W | First memory address |
| byte_count_i | input | CNT_W | Number of bytes to write |
| poll_mode_i | input | 1 | 0: data-compare polling, 1: bit-6 toggle polling |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Controller takes the byte this cycle |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dout_o | output | 8 | Write data toward the memory |
| mem_drive_o | output | 1 | Host drives the data bus |
| mem_din_i | input | 8 | Read data from the memory |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_err_o | output | 1 | Poll timeout, held until next start |

## Verification
The bench builds the controller with an 11-bit address, an 8-bit count, a 40-cycle load window, a 400-cycle poll limit and one-, two- and two-cycle setup, strobe and read phases. It pairs this with a memory model that starts programming 48 cycles after a strobe, or at the first read, and stays busy for 60 cycles. At these sizes a short stall is enough to close a run early, a 70-byte block spans a full page and a partial one, and a model held busy trips the poll timeout within a few hundred cycles. The model flags any strobe during programming, any late strobe, any page change inside a run, wrong strobe widths and poll reads at the wrong address.

// File: rtl/eprog_pkg.sv
package eprog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER,
    ST_PSETUP,
    ST_PREAD,
    ST_PGAP,
    ST_DONE
  } eprog_state_e;

  localparam logic POLL_COMPARE = 1'b0;
  localparam logic POLL_TOGGLE  = 1'b1;

endpackage

// File: rtl/eprog_phase_timer.sv
// Down-counter that times the setup, strobe and read phases.
module eprog_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/eprog_window_timer.sv
// Counts cycles since the last strobe fall and flags when no further
// strobe could still fall inside the load window.
module eprog_window_timer #(
  parameter int WINDOW_CYC = 10000,
  parameter int SETUP_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_i,
  output logic late_o
);

  localparam int W       = $clog2(WINDOW_CYC + 1);
  localparam int LATE_AT = WINDOW_CYC - SETUP_CYC;
  localparam logic [W-1:0] CNT_MAX = W'(WINDOW_CYC);
  localparam logic [W-1:0] LATE_V  = W'(LATE_AT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = mark_i || (cnt_q != CNT_MAX);
    cnt_d  = mark_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_MAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign late_o = (cnt_q >= LATE_V);

endmodule

// File: rtl/eprog_poll_unit.sv
// Judges each poll read and times the poll phase.
module eprog_poll_unit #(
  parameter int POLL_TIMEOUT = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       begin_i,
  input  logic       sample_i,
  input  logic       mode_i,
  input  logic [7:0] din_i,
  input  logic [7:0] ref_i,
  output logic       match_o,
  output logic       timeout_o
);

  localparam int W = $clog2(POLL_TIMEOUT + 1);
  localparam logic [W-1:0] TO_V = W'(POLL_TIMEOUT);

  logic [W-1:0] to_q, to_d;
  logic         to_en;
  logic         prev6_q, have_prev_q;
  logic         prev6_d, have_prev_d;
  logic         hist_en;

  always_comb begin
    to_en = begin_i || (to_q != TO_V);
    to_d  = begin_i ? '0 : to_q + W'(1);
    hist_en     = begin_i || sample_i;
    prev6_d     = din_i[6];
    have_prev_d = !begin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     to_q <= '0;
    else if (to_en) to_q <= to_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (hist_en) begin
      prev6_q     <= prev6_d;
      have_prev_q <= have_prev_d;
    end
  end

  always_comb begin
    if (mode_i == eprog_pkg::POLL_TOGGLE) match_o = have_prev_q && (din_i[6] == prev6_q);
    else                                  match_o = (din_i == ref_i);
  end

  assign timeout_o = (to_q == TO_V);

endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog
  import eprog_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 6,
  parameter int CNT_W        = 14,
  parameter int SETUP_CYC    = 2,
  parameter int STROBE_CYC   = 4,
  parameter int READ_CYC     = 4,
  parameter int WINDOW_CYC   = 10000,
  parameter int POLL_TIMEOUT = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              poll_mode_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_dout_o,
  output logic              mem_drive_o,
  input  logic [7:0]        mem_din_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_err_o
);

  localparam int PH_MAX0 = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int PH_MAX  = (PH_MAX0 > READ_CYC) ? PH_MAX0 : READ_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] PH_SETUP  = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0] PH_STROBE = PH_W'(STROBE_CYC - 1);
  localparam logic [PH_W-1:0] PH_READ   = PH_W'(READ_CYC - 1);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  eprog_state_e      state_q, state_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [ADDR_W-1:0] poll_addr_q, poll_addr_d;
  logic [7:0]        data_q, data_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              mode_q, mode_d;
  logic              err_q, err_d;
  logic              run_open_q, run_open_d;

  logic              ph_load, ph_zero;
  logic [PH_W-1:0]   ph_val;
  logic              win_mark, win_late;
  logic              poll_begin, poll_sample, poll_match, poll_timeout;
  logic [ADDR_W-1:0] wr_next;

  eprog_phase_timer #(.W(PH_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (ph_load),
    .load_val_i (ph_val),
    .zero_o     (ph_zero)
  );

  eprog_window_timer #(.WINDOW_CYC(WINDOW_CYC), .SETUP_CYC(SETUP_CYC)) u_window (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mark_i (win_mark),
    .late_o (win_late)
  );

  eprog_poll_unit #(.POLL_TIMEOUT(POLL_TIMEOUT)) u_poll (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .begin_i   (poll_begin),
    .sample_i  (poll_sample),
    .mode_i    (mode_q),
    .din_i     (mem_din_i),
    .ref_i     (data_q),
    .match_o   (poll_match),
    .timeout_o (poll_timeout)
  );

  assign wr_next = wr_addr_q + ADDR_W'(1);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    wr_addr_d   = wr_addr_q;
    poll_addr_d = poll_addr_q;
    data_d      = data_q;
    rem_d       = rem_q;
    mode_d      = mode_q;
    err_d       = err_q;
    run_open_d  = run_open_q;
    ph_load     = 1'b0;
    ph_val      = '0;
    win_mark    = 1'b0;
    poll_begin  = 1'b0;
    poll_sample = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          wr_addr_d  = start_addr_i;
          rem_d      = byte_count_i;
          mode_d     = poll_mode_i;
          err_d      = 1'b0;
          run_open_d = 1'b0;
          state_d    = (byte_count_i == '0) ? ST_DONE : ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (run_open_q && win_late) begin
          run_open_d = 1'b0;
          poll_begin = 1'b1;
          state_d    = ST_PSETUP;
        end else if (in_valid_i) begin
          data_d  = in_data_i;
          ph_load = 1'b1;
          ph_val  = PH_SETUP;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          ph_load     = 1'b1;
          ph_val      = PH_STROBE;
          win_mark    = 1'b1;
          poll_addr_d = wr_addr_q;
          state_d     = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (ph_zero) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        rem_d     = rem_q - CNT_W'(1);
        wr_addr_d = wr_next;
        if ((rem_q == CNT_W'(1)) || (wr_next[PAGE_W-1:0] == '0)) begin
          run_open_d = 1'b0;
          poll_begin = 1'b1;
          state_d    = ST_PSETUP;
        end else begin
          run_open_d = 1'b1;
          state_d    = ST_LOAD;
        end
      end
      ST_PSETUP: begin
        ph_load = 1'b1;
        ph_val  = PH_READ;
        state_d = ST_PREAD;
      end
      ST_PREAD: begin
        if (ph_zero) begin
          poll_sample = 1'b1;
          if (poll_match) state_d = (rem_q == '0) ? ST_DONE : ST_LOAD;
          else            state_d = ST_PGAP;
        end
      end
      ST_PGAP: begin
        if (poll_timeout) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_PSETUP;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q     <= ST_IDLE;
      wr_addr_q   <= '0;
      poll_addr_q <= '0;
      data_q      <= '0;
      rem_q       <= '0;
      mode_q      <= POLL_COMPARE;
      err_q       <= 1'b0;
      run_open_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      wr_addr_q   <= wr_addr_d;
      poll_addr_q <= poll_addr_d;
      data_q      <= data_d;
      rem_q       <= rem_d;
      mode_q      <= mode_d;
      err_q       <= err_d;
      run_open_q  <= run_open_d;
    end
  end

  // bus and status decode
  logic in_poll;
  assign in_poll       = (state_q == ST_PSETUP) || (state_q == ST_PREAD) || (state_q == ST_PGAP);
  assign mem_we_n_o    = (state_q != ST_STROBE);
  assign mem_oe_n_o    = (state_q != ST_PREAD);
  assign mem_ce_n_o    = !((state_q == ST_STROBE) || (state_q == ST_PREAD));
  assign mem_drive_o   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_RECOVER);
  assign mem_addr_o    = in_poll ? poll_addr_q : wr_addr_q;
  assign mem_dout_o    = data_q;
  assign in_ready_o    = (state_q == ST_LOAD) && !(run_open_q && win_late);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign timeout_err_o = err_q;

  // checker state watching the bus pins
  localparam int GAP_W = $clog2(WINDOW_CYC + 2);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(WINDOW_CYC + 1);
  logic                     chk_we_prev_q, chk_run_q, chk_fall;
  logic [GAP_W-1:0]         chk_gap_q;
  logic [ADDR_W-PAGE_W-1:0] chk_page_q;
  assign chk_fall = chk_we_prev_q && !mem_we_n_o;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      chk_we_prev_q <= 1'b1;
      chk_run_q     <= 1'b0;
      chk_gap_q     <= '0;
      chk_page_q    <= '0;
    end else begin
      chk_we_prev_q <= mem_we_n_o;
      if (chk_fall) begin
        chk_gap_q  <= GAP_W'(1);
        chk_run_q  <= 1'b1;
        chk_page_q <= mem_addr_o[ADDR_W-1:PAGE_W];
      end else begin
        if (chk_gap_q != GAP_SAT) chk_gap_q <= chk_gap_q + GAP_W'(1);
        if (!mem_oe_n_o) chk_run_q <= 1'b0;
      end
    end
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !mem_drive_o && !in_ready_o));
  assert_strobe_shape_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_we_n_o |-> (!mem_ce_n_o && mem_oe_n_o && mem_drive_o));
  assert_take_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready_o |-> (mem_ce_n_o && mem_we_n_o));
  assert_same_page_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_fall && chk_run_q) |-> (mem_addr_o[ADDR_W-1:PAGE_W] == chk_page_q));
  assert_load_window_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chk_fall && chk_run_q) |-> (chk_gap_q <= GAP_W'(WINDOW_CYC)));
  assert_poll_shape_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o && !mem_drive_o));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  assert_err_no_done_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    timeout_err_o |-> !done_o);

endmodule

// File: tb/tb_eeprom_page_prog.sv
`timescale 1ns/1ps
module tb_eeprom_page_prog;

  localparam int AW = 11, PW = 6, CW = 8;
  localparam int SETUP = 1, STROBE = 2, READ = 2, WIN = 40, PTO = 400;
  localparam int MWIN = 48, PROG = 60;

  logic clk, rst_n;
  logic start, poll_mode, in_valid, in_ready;
  logic [AW-1:0] start_addr, mem_addr;
  logic [CW-1:0] byte_count;
  logic [7:0] in_data, mem_dout, mem_din;
  logic ce_n, oe_n, we_n, drive, busy, done, err;

  eeprom_page_prog #(
    .ADDR_W(AW), .PAGE_W(PW), .CNT_W(CW), .SETUP_CYC(SETUP), .STROBE_CYC(STROBE),
    .READ_CYC(READ), .WINDOW_CYC(WIN), .POLL_TIMEOUT(PTO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .byte_count_i(byte_count), .poll_mode_i(poll_mode), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
    .mem_we_n_o(we_n), .mem_addr_o(mem_addr), .mem_dout_o(mem_dout), .mem_drive_o(drive),
    .mem_din_i(mem_din), .busy_o(busy), .done_o(done), .timeout_err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0, done_cnt = 0;

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      report();
      $finish;
    end
  end

  // memory model
  logic [7:0] mem [0:(1<<AW)-1];
  logic m_prog, m_tog, stuck;
  logic [7:0] m_last;
  logic we_q, oe_q;
  int loaded, gap, pcnt, wlow, viol, n_prog, n_falls, max_gap;
  logic [AW-1:0] m_lastaddr;
  logic [AW-PW-1:0] m_page;

  assign mem_din = m_prog ? {~m_last[7], m_tog, m_last[5:0]} : mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog <= 1'b0; m_tog <= 1'b0; m_last <= 8'h00; we_q <= 1'b1; oe_q <= 1'b1;
      loaded = 0; gap = 0; pcnt = 0; wlow = 0;
    end else begin
      we_q <= we_n; oe_q <= oe_n;
      if (loaded > 0) gap++;
      if (!we_n && (ce_n || !oe_n || !drive)) viol++;
      if (!oe_n && (ce_n || drive || !we_n)) viol++;
      if (!we_n) wlow++;
      if (we_q && !we_n) begin
        n_falls++;
        if (m_prog) viol++;
        if (loaded > 0) begin
          if (mem_addr[AW-1:PW] != m_page) viol++;
          if (gap > max_gap) max_gap = gap;
        end
        m_page = mem_addr[AW-1:PW];
        m_lastaddr = mem_addr;
        loaded++;
        gap = 0;
      end
      if (!we_q && we_n) begin
        if (wlow != STROBE) viol++;
        wlow = 0;
        mem[mem_addr] <= mem_dout;
        m_last <= mem_dout;
      end
      if (oe_q && !oe_n) begin
        if (mem_addr != m_lastaddr) viol++;
        if (m_prog) m_tog <= ~m_tog;
      end
      if (m_prog) begin
        pcnt++;
        if (pcnt >= PROG && !stuck) m_prog <= 1'b0;
      end else if (loaded > 0 && ((oe_q && !oe_n) || gap >= MWIN)) begin
        m_prog <= 1'b1; pcnt = 0; n_prog++; loaded = 0; gap = 0;
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 29 + (i >> 3));
  endfunction

  task automatic push(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input int addr, input int n, input logic mode, input int seed,
                        input int stall_at, input int stall_len);
    start = 1'b1; start_addr = AW'(addr); byte_count = CW'(n); poll_mode = mode;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) repeat (stall_len) @(negedge clk);
      push(pat(seed, i));
    end
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic verify(input int addr, input int n, input int seed, input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < n; i++)
      if (mem[addr + i] !== pat(seed, i)) begin bad++; if (first < 0) first = i; end
    check(bad == 0, req, "bytes differing from stream", bad, 0);
  endtask

  task automatic clear_stats();
    viol = 0; n_prog = 0; max_gap = 0;
  endtask

  task automatic t_reset();
    check(ce_n && oe_n && we_n, "R1", "controls high in reset", {ce_n, oe_n, we_n}, 7);
    check(!drive && !in_ready, "R1", "drive/ready low", {drive, in_ready}, 0);
    check(!busy && !done && !err, "R1", "busy/done/err low", {busy, done, err}, 0);
  endtask

  task automatic t_cross_page();
    int d0 = done_cnt;
    clear_stats();
    run_op('h3C, 10, 1'b0, 5, -1, 0);
    verify('h3C, 10, 5, "R3");
    check(n_prog == 2, "R4", "programming cycles across page", n_prog, 2);
    check(viol == 0, "R2", "bus protocol violations", viol, 0);
    check(done_cnt - d0 == 1, "R9", "done pulse cycles", done_cnt - d0, 1);
    check(!busy && ce_n && we_n && oe_n, "R9", "idle after done", busy, 0);
    check(max_gap <= WIN, "R5", "largest strobe gap", max_gap, WIN);
  endtask

  task automatic t_toggle_mode();
    int d0 = done_cnt;
    clear_stats();
    run_op('h105, 5, 1'b1, 77, -1, 0);
    verify('h105, 5, 77, "R7");
    check(n_prog == 1, "R7", "single run programming cycles", n_prog, 1);
    check(viol == 0, "R8", "violations in toggle mode", viol, 0);
    check(done_cnt - d0 == 1, "R7", "done after toggle polling", done_cnt - d0, 1);
  endtask

  task automatic t_stall();
    clear_stats();
    run_op('h200, 6, 1'b0, 140, 3, 80);
    verify('h200, 6, 140, "R5");
    check(n_prog == 2, "R5", "stall closes run early", n_prog, 2);
    check(max_gap <= WIN, "R5", "largest strobe gap", max_gap, WIN);
    check(viol == 0, "R6", "poll address and write-while-busy", viol, 0);
  endtask

  task automatic t_full_page();
    clear_stats();
    run_op('h440, 70, 1'b1, 201, -1, 0);
    verify('h440, 70, 201, "R4");
    check(n_prog == 2, "R4", "64-byte run then 6-byte run", n_prog, 2);
    check(viol == 0, "R8", "violations over full page", viol, 0);
  endtask

  task automatic t_zero();
    int f0 = n_falls, d0 = done_cnt;
    start = 1'b1; start_addr = AW'('h300); byte_count = '0; poll_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R11", "done one cycle after start", done, 1);
    @(negedge clk);
    check(!done && !busy, "R11", "done ends, idle", {done, busy}, 0);
    check(n_falls == f0, "R11", "strobes issued", n_falls - f0, 0);
    check(done_cnt - d0 == 1, "R11", "done pulses", done_cnt - d0, 1);
  endtask

  task automatic t_timeout();
    int d0 = done_cnt;
    clear_stats();
    stuck = 1'b1;
    run_op('h600, 3, 1'b0, 9, -1, 0);
    check(err === 1'b1, "R10", "timeout flag", err, 1);
    check(!busy, "R10", "busy after timeout", busy, 0);
    check(done_cnt == d0, "R10", "done pulses on timeout", done_cnt - d0, 0);
    repeat (5) @(negedge clk);
    check(err === 1'b1, "R10", "timeout flag held", err, 1);
    stuck = 1'b0;
    repeat (10) @(negedge clk);
    d0 = done_cnt;
    run_op('h700, 2, 1'b1, 33, -1, 0);
    check(err === 1'b0, "R10", "flag cleared by new start", err, 0);
    check(done_cnt - d0 == 1, "R10", "recovery operation done", done_cnt - d0, 1);
    verify('h700, 2, 33, "R10");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0; poll_mode = 1'b0;
    in_valid = 1'b0; in_data = '0; stuck = 1'b0;
    viol = 0; n_prog = 0; n_falls = 0; max_gap = 0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_cross_page();
    t_toggle_mode();
    t_stall();
    t_full_page();
    t_zero();
    t_timeout();
    report();
    $finish;
  end

endmodule